// File: doc/BRIEF.md
# Vector Register-Group Legality Checker

This block sits right after a vector instruction decoder. It decides whether a decoded instruction is a reserved encoding under the group-size (LMUL) setting that is currently in force. Whether an instruction is legal depends on that runtime setting as well as on the instruction bits. For example, the same widening add can be legal at one group size and violate several rules at another.

Each rule is evaluated on its own. The result is a five-bit reason vector, so a trap handler or a debug log can see every violated rule at once rather than a single "bad encoding" bit. The result is registered. It appears one clock after the cycle in which the input strobe was high, together with an output strobe.

The block considers three operands: a destination, a first source and a second source. Each operand's group size follows from the operation class and LMUL. Alignment, group size, the masked-v0 case, segment overflow and a simplified overlap test are then computed in parallel.

Top module: `vrg_legality_check`

## Requirements
- R1: The LMUL code `lmul_code` maps as 0→1, 1→2, 2→4, 3→8, 5→1/8, 6→1/4, 7→1/2. Code 4 is reserved, and an accepted instruction under code 4 reports all five reason bits set.
- R2: The operation class `op_class` maps as 0 plain, 1 widening, 2 narrowing, 3 mask-producing, 4 segment load/store; codes 5 to 7 behave as plain. The group size of each operand is as follows. The destination of a widening operation uses 2×LMUL. The second (wide) source of a narrowing operation uses 2×LMUL. Every other operand uses LMUL. A fractional value counts as one register. Segment instructions check only the destination, and their sources are ignored.
- R3: Reason bit 0 (misaligned) is set when any checked operand's register number is not a multiple of its group size.
- R4: Reason bit 1 (oversized) is set when any checked operand's group size exceeds 8 registers.
- R5: Reason bit 2 (masked v0) is set when `masked` is 1 and `vd` is 0, unless the class is mask-producing. It is set under every LMUL setting.
- R6: Reason bit 3 (segment overflow) is set for class 4 when `vd + (seg_nf+1)×LMUL` exceeds 32. `seg_nf` holds the field count minus one.
- R7: Reason bit 4 (overlap) is set for class 1 when the lowest LMUL registers of the destination group intersect the group of either source. The group size for this test is taken as LMUL, with a fractional value counting as one.
- R8: `illegal` equals the OR of the five reason bits.
- R9: Results appear one cycle after the cycle in which `in_valid` is high, with `out_valid` high. In a cycle after `in_valid` was low, `out_valid`, `illegal` and `reason` are all zero.
- R10: A synchronous active-high reset clears `out_valid`, `illegal` and `reason` to zero, and it takes priority over `in_valid`.
- R11: A widening instruction with vd=2, vs2=3 and vs1=4 reports no reason at LMUL 1. At LMUL 8 it reports exactly three bits: misaligned, oversized and overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| vd | input | 5 | Destination register number (segment base register) |
| vs1 | input | 5 | First source register number |
| vs2 | input | 5 | Second source register number (wide source for narrowing) |
| masked | input | 1 | Instruction is masked by v0 |
| seg_nf | input | 3 | Segment field count minus one |
| op_class | input | 3 | Operation class code |
| lmul_code | input | 3 | Current LMUL code from the vector type setting |
| out_valid | output | 1 | Result strobe |
| illegal | output | 1 | At least one rule violated |
| reason | output | 5 | Bit 0 misaligned, 1 oversized, 2 masked v0, 3 segment overflow, 4 overlap |

## Verification
The hardest situation to reach is several rules firing at once in the right combination. The widening case at LMUL 8 needs an operand group of 16 registers that is both misaligned and overlapping, while the same registers must stay clean at LMUL 1. The stimulus sweeps every destination register across every LMUL code, every class and both mask settings, using a small source set chosen to straddle group boundaries. For segment instructions it also sweeps every field count, so the end of the register file is crossed from many base registers. The expected vector for each case comes from a separate arithmetic model of the rules.

// File: rtl/vrg_pkg.sv
package vrg_pkg;

    localparam int VREG_COUNT = 32;
    localparam int VREG_W     = $clog2(VREG_COUNT);
    localparam int LG_W       = 3;
    localparam int NF_W       = 3;
    localparam int MAX_LOG    = 3;
    localparam int N_OPND     = 3;
    localparam int RSN_W      = 5;
    localparam int SPAN_W     = VREG_W + 5;

    localparam logic [2:0] LMUL_RESERVED = 3'd4;

    typedef enum logic [2:0] {
        CLS_PLAIN   = 3'd0,
        CLS_WIDEN   = 3'd1,
        CLS_NARROW  = 3'd2,
        CLS_MASKOUT = 3'd3,
        CLS_SEGMENT = 3'd4
    } op_class_e;

    typedef struct packed {
        logic overlap;
        logic seg_over;
        logic mask_v0;
        logic oversize;
        logic misalign;
    } reason_t;

    typedef struct packed {
        logic              used;
        logic [VREG_W-1:0] base;
        logic [LG_W-1:0]   lg;
    } operand_t;

    function automatic logic is_reserved(input logic [2:0] code);
        return code == LMUL_RESERVED;
    endfunction

    function automatic logic [LG_W-1:0] group_log(input logic [2:0] code);
        return code[2] ? '0 : LG_W'(code);
    endfunction

    function automatic logic [LG_W-1:0] wide_log(input logic [2:0] code);
        return code[2] ? '0 : LG_W'(code) + LG_W'(1);
    endfunction

    function automatic logic group_aligned(input logic [VREG_W-1:0] base,
                                           input logic [LG_W-1:0]   lg);
        logic [VREG_W:0] msk;
        msk = ((VREG_W+1)'(1) << lg) - (VREG_W+1)'(1);
        return ({1'b0, base} & msk) == '0;
    endfunction

    function automatic logic groups_hit(input logic [VREG_W-1:0] a,
                                        input logic [VREG_W-1:0] b,
                                        input logic [LG_W-1:0]   lg);
        logic [VREG_W+3:0] n, a_x, b_x;
        n   = (VREG_W+4)'(1) << lg;
        a_x = {4'b0, a};
        b_x = {4'b0, b};
        return (a_x < b_x + n) && (b_x < a_x + n);
    endfunction

endpackage

// File: rtl/vrg_emul_map.sv
module vrg_emul_map
    import vrg_pkg::*;
(
    input  logic [2:0]        op_class,
    input  logic [2:0]        lmul_code,
    input  logic [VREG_W-1:0] vd,
    input  logic [VREG_W-1:0] vs1,
    input  logic [VREG_W-1:0] vs2,
    output operand_t          opnd [N_OPND],
    output logic [LG_W-1:0]   base_lg,
    output logic              reserved
);

    logic [LG_W-1:0] lg_n;
    logic [LG_W-1:0] lg_w;

    assign lg_n     = group_log(lmul_code);
    assign lg_w     = wide_log(lmul_code);
    assign base_lg  = lg_n;
    assign reserved = is_reserved(lmul_code);

    always_comb begin
        opnd[0] = '{used: 1'b1, base: vd,  lg: lg_n};
        opnd[1] = '{used: 1'b1, base: vs1, lg: lg_n};
        opnd[2] = '{used: 1'b1, base: vs2, lg: lg_n};
        case (op_class)
            CLS_WIDEN:   opnd[0].lg = lg_w;
            CLS_NARROW:  opnd[2].lg = lg_w;
            CLS_SEGMENT: begin
                opnd[1].used = 1'b0;
                opnd[2].used = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vrg_rule_eval.sv
module vrg_rule_eval
    import vrg_pkg::*;
(
    input  operand_t          opnd [N_OPND],
    input  logic [LG_W-1:0]   base_lg,
    input  logic              reserved,
    input  logic [2:0]        op_class,
    input  logic              masked,
    input  logic [NF_W-1:0]   seg_nf,
    output reason_t           why
);

    logic [N_OPND-1:0] mis_v;
    logic [N_OPND-1:0] big_v;

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        assign mis_v[i] = opnd[i].used && !group_aligned(opnd[i].base, opnd[i].lg);
        assign big_v[i] = opnd[i].used && (opnd[i].lg > LG_W'(MAX_LOG));
    end

    logic [SPAN_W-1:0] seg_span;
    logic [SPAN_W-1:0] seg_end;
    logic              seg_bad;
    logic              ovl_bad;
    logic              mv0_bad;

    always_comb begin
        seg_span = (SPAN_W'(seg_nf) + SPAN_W'(1)) << base_lg;
        seg_end  = seg_span + SPAN_W'(opnd[0].base);
        seg_bad  = (op_class == CLS_SEGMENT) && (seg_end > SPAN_W'(VREG_COUNT));
    end

    assign ovl_bad = (op_class == CLS_WIDEN) &&
                     (groups_hit(opnd[0].base, opnd[1].base, base_lg) ||
                      groups_hit(opnd[0].base, opnd[2].base, base_lg));

    assign mv0_bad = masked && (opnd[0].base == '0) && (op_class != CLS_MASKOUT);

    always_comb begin
        if (reserved) begin
            why = '1;
        end else begin
            why.misalign = |mis_v;
            why.oversize = |big_v;
            why.mask_v0  = mv0_bad;
            why.seg_over = seg_bad;
            why.overlap  = ovl_bad;
        end
    end

endmodule

// File: rtl/vrg_out_stage.sv
module vrg_out_stage
    import vrg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  reason_t why,
    output logic    out_valid,
    output logic    illegal,
    output reason_t reason_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            reason_q  <= '0;
        end else begin
            out_valid <= in_valid;
            illegal   <= in_valid && (|why);
            reason_q  <= in_valid ? why : '0;
        end
    end

endmodule

// File: rtl/vrg_legality_check.sv
module vrg_legality_check
    import vrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VREG_W-1:0] vd,
    input  logic [VREG_W-1:0] vs1,
    input  logic [VREG_W-1:0] vs2,
    input  logic              masked,
    input  logic [NF_W-1:0]   seg_nf,
    input  logic [2:0]        op_class,
    input  logic [2:0]        lmul_code,
    output logic              out_valid,
    output logic              illegal,
    output logic [RSN_W-1:0]  reason
);

    operand_t        opnd [N_OPND];
    logic [LG_W-1:0] base_lg;
    logic            reserved;
    reason_t         why;
    reason_t         reason_q;

    vrg_emul_map u_map (
        .op_class  (op_class),
        .lmul_code (lmul_code),
        .vd        (vd),
        .vs1       (vs1),
        .vs2       (vs2),
        .opnd      (opnd),
        .base_lg   (base_lg),
        .reserved  (reserved)
    );

    vrg_rule_eval u_rules (
        .opnd     (opnd),
        .base_lg  (base_lg),
        .reserved (reserved),
        .op_class (op_class),
        .masked   (masked),
        .seg_nf   (seg_nf),
        .why      (why)
    );

    vrg_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .why       (why),
        .out_valid (out_valid),
        .illegal   (illegal),
        .reason_q  (reason_q)
    );

    assign reason = reason_q;

endmodule

// File: rtl/vrg_legality_sva.sv
module vrg_legality_sva
    import vrg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [VREG_W-1:0] vd,
    input logic              masked,
    input logic [2:0]        op_class,
    input logic [2:0]        lmul_code,
    input logic              out_valid,
    input logic              illegal,
    input logic [RSN_W-1:0]  reason
);

    assert_reserved_all_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid && lmul_code == LMUL_RESERVED |=> reason == '1);

    assert_small_no_oversize_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && lmul_code <= 3'd2 |=> !reason[1]);

    assert_masked_v0_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && masked && vd == '0 && op_class == 3'd0 |=> reason[2]);

    assert_no_overlap_plain_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_class == 3'd0 && lmul_code != LMUL_RESERVED |=> !reason[4]);

    assert_illegal_or_R8: assert property (@(posedge clk) disable iff (rst)
        illegal == (|reason));

    assert_strobe_follow_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !illegal && reason == '0);

endmodule

bind vrg_legality_check vrg_legality_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .vd        (vd),
    .masked    (masked),
    .op_class  (op_class),
    .lmul_code (lmul_code),
    .out_valid (out_valid),
    .illegal   (illegal),
    .reason    (reason)
);

// File: tb/vrg_legality_check_test.sv
module vrg_legality_check_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [4:0] vd, vs1, vs2;
    logic       masked;
    logic [2:0] seg_nf, op_class, lmul_code;
    logic       out_valid, illegal;
    logic [4:0] reason;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    vrg_legality_check uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .vd(vd), .vs1(vs1), .vs2(vs2), .masked(masked),
        .seg_nf(seg_nf), .op_class(op_class), .lmul_code(lmul_code),
        .out_valid(out_valid), .illegal(illegal), .reason(reason)
    );

    function automatic bit hits(int a, int b, int n);
        return (a < b + n) && (b < a + n);
    endfunction

    // arithmetic model of R1..R7
    function automatic logic [4:0] model(int lc, int cls, int msk, int d, int s1, int s2, int nf);
        int lg, l, w, de, e1, e2, c;
        bit use_s, mis, big, mv, sg, ov;
        if (lc == 4) return 5'h1f;
        lg = (lc < 4) ? lc : lc - 8;
        l  = (lg < 0) ? 1 : (1 << lg);
        w  = (lg + 1 < 0) ? 1 : (1 << (lg + 1));
        c  = (cls >= 5) ? 0 : cls;
        de = l; e1 = l; e2 = l; use_s = 1;
        if (c == 1) de = w;
        if (c == 2) e2 = w;
        if (c == 4) use_s = 0;
        mis = (d % de != 0) || (use_s && ((s1 % e1 != 0) || (s2 % e2 != 0)));
        big = (de > 8) || (use_s && (e1 > 8 || e2 > 8));
        mv  = (msk != 0) && (d == 0) && (c != 3);
        sg  = (c == 4) && (d + (nf + 1) * l > 32);
        ov  = (c == 1) && (hits(d, s1, l) || hits(d, s2, l));
        return {ov, sg, mv, big, mis};
    endfunction

    task automatic check(string tag, logic v, logic il, logic [4:0] r, logic [4:0] er);
        logic eil;
        eil = |er;
        checks++;
        if (out_valid !== v || illegal !== (v ? eil : 1'b0) || reason !== er) begin
            errors++;
            $display("FAIL %s: got valid=%b illegal=%b reason=%b expected valid=%b illegal=%b reason=%b",
                     tag, out_valid, il, r, v, v ? eil : 1'b0, er);
        end
    endtask

    // at a negedge: drive, wait one cycle, check at next negedge
    task automatic apply(string tag, int lc, int cls, int msk, int d, int s1, int s2, int nf);
        in_valid  = 1'b1;
        lmul_code = 3'(lc); op_class = 3'(cls); masked = msk[0];
        vd = 5'(d); vs1 = 5'(s1); vs2 = 5'(s2); seg_nf = 3'(nf);
        @(negedge clk);
        check(tag, 1'b1, illegal, reason, model(lc, cls, msk, d, s1, s2, nf));
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int src [5] = '{0, 1, 2, 4, 8};
        int cl  [5] = '{0, 1, 2, 3, 5};
        rst = 1'b1; in_valid = 1'b0; vd = '0; vs1 = '0; vs2 = '0;
        masked = 1'b0; seg_nf = '0; op_class = '0; lmul_code = 3'd4;
        repeat (3) @(negedge clk);
        check("R10 reset state", 1'b0, illegal, reason, 5'h00);

        rst = 1'b0;
        // R11 directed widening example
        apply("R11 widen LMUL1", 0, 1, 0, 2, 4, 3, 0);
        if (reason !== 5'b00000) $display("FAIL R11 expected clean at LMUL1 got %b", reason);
        apply("R11 widen LMUL8", 3, 1, 0, 2, 4, 3, 0);
        checks++;
        if (reason !== 5'b10011) begin
            errors++;
            $display("FAIL R11 LMUL8 got %b expected 10011", reason);
        end
        // R5 masked v0 plain add under every LMUL code
        for (int lc = 0; lc < 8; lc++) begin
            apply("R5 masked v0", lc, 0, 1, 0, 8, 16, 0);
            checks++;
            if (reason[2] !== 1'b1) begin
                errors++;
                $display("FAIL R5 lmul=%0d got %b expected bit2 set", lc, reason);
            end
        end
        // R1 reserved code
        apply("R1 reserved LMUL", 4, 0, 0, 8, 8, 8, 0);
        // R9 idle after reserved-looking inputs
        in_valid = 1'b0; lmul_code = 3'd4; masked = 1'b1; vd = '0;
        @(negedge clk);
        check("R9 idle cycle", 1'b0, illegal, reason, 5'h00);
        // R10 reset wins over in_valid
        apply("R6 segment overflow", 0, 4, 0, 30, 0, 0, 3);
        rst = 1'b1; in_valid = 1'b1; lmul_code = 3'd4;
        @(negedge clk);
        check("R10 reset priority", 1'b0, illegal, reason, 5'h00);
        rst = 1'b0;

        // R2 R3 R4 R5 R7 R8 sweep, non-segment classes
        for (int lc = 0; lc < 8; lc++)
            for (int ci = 0; ci < 5; ci++)
                for (int m = 0; m < 2; m++)
                    for (int d = 0; d < 32; d++)
                        for (int a = 0; a < 5; a++)
                            for (int b = 0; b < 5; b++)
                                apply("R2-sweep R3 R4 R5 R7 R8", lc, cl[ci], m, d, src[a], src[b], 0);
        // R6 sweep, segment class, sources ignored (R2)
        for (int lc = 0; lc < 8; lc++)
            for (int m = 0; m < 2; m++)
                for (int d = 0; d < 32; d++)
                    for (int nf = 0; nf < 8; nf++)
                        apply("R6 segment sweep", lc, 4, m, d, (d * 7 + 1) % 32, (d + nf) % 32, nf);

        in_valid = 1'b0;
        @(negedge clk);
        check("R9 final idle", 1'b0, illegal, reason, 5'h00);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule